// File: doc/BRIEF.md
# Multi-Channel Memory Address Interleaver

This block sits between a requester that issues flat physical byte addresses and a controller that owns up to four DRAM channels, one module slot per channel. When a configure strobe arrives it samples a descriptor for each slot: present bit, capacity, speed grade and CAS latency. It then picks how addresses are spread: interleaved across 2, 3 or 4 matched channels, a flex split for two channels of unequal size, or plain linear concatenation. For the two-channel case it can also gang both channels into one 128-bit logical channel.

Each request carries one byte address and enters through a valid/ready handshake. The block answers with a one-hot channel select, the address inside that channel, a wide flag and an out-of-range flag. The result appears from a single output register one cycle after acceptance. Back-pressure works as follows. `req_ready` is high whenever the output register is empty or is being drained this cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken. The common speed and CAS latency are plain status outputs.

Capacity is counted in 64-byte granules. Granule number g = addr / 64, offset = addr % 64, and the local address is always (local granule * 64 + offset), except in ganged operation.

Top module: `mchan_interleaver`

## Requirements
- R1: On `cfg_load`, the mode is chosen from the present slots and reported on `mode`. Code 3 (quad) means four present modules with equal capacity and speed. Code 2 (triple) means exactly three such modules. Code 1 (dual) means exactly two such modules. Code 4 (flex) means exactly two modules with equal speed and unequal capacity. Every other population gives code 0 (linear).
- R2: In dual and quad modes, let L be the list of present slots in ascending index order and k the number of channels. Granule g goes to slot L[g mod k], at local granule g / k.
- R3: In triple mode, granule g goes to slot L[g mod 3] at local granule g / 3.
- R4: In flex mode, let m be the smaller capacity. Granules below 2m alternate over L[0], L[1] with local granule g / 2. Higher granules go to the larger module at local granule g - m.
- R5: In linear mode, present slots are concatenated in ascending index order. A granule maps to the slot whose range holds it, at an offset from that slot's base.
- R6: With a ganged request in dual mode, `ganged` is 1 and every in-range response sets both channel bits and `rsp_wide`. The local address is the byte address divided by 2.
- R7: Outside ganged operation, every in-range response has exactly one bit of `rsp_ch` set and `rsp_wide` low.
- R8: A granule number at or above the total installed capacity gives `rsp_err` = 1, `rsp_ch` = 0, `rsp_laddr` = 0 and `rsp_wide` = 0.
- R9: `common_speed` is the minimum speed grade among present modules and `common_cas` is the maximum CAS latency among them. Both are 0 when no module is present.
- R10: `cfg_warn` is 1 when no module is present, or when a ganged request meets a mode other than dual. In that case `ganged` stays 0 and the mapping falls back to the unganged or linear form.
- R11: A request accepted on a clock edge appears on the response outputs right after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response is held and `req_ready` is low.
- R12: Changes on the configuration inputs without `cfg_load` change neither the mode nor the mapping. After reset, the mode is 0, `ganged`, `cfg_warn` and `rsp_valid` are 0, and every address reports an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Samples the slot descriptors and mode request |
| cfg_present | input | NCH | Slot i holds a module |
| cfg_cap | input | NCH*CAP_W | Per-slot capacity in 64-byte granules, slot i at bits [i*CAP_W +: CAP_W] |
| cfg_speed | input | NCH*SPD_W | Per-slot speed grade, larger is faster |
| cfg_cas | input | NCH*CL_W | Per-slot CAS latency |
| cfg_gang_req | input | 1 | Ask for ganged two-channel operation |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Flat byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_ch | output | NCH | One-hot channel select, bit i = slot i |
| rsp_laddr | output | CAP_W+6 | Channel-local byte address |
| rsp_wide | output | 1 | Access spans both ganged channels |
| rsp_err | output | 1 | Address beyond installed capacity |
| mode | output | 3 | Active mode code (R1) |
| ganged | output | 1 | Ganged operation active |
| cfg_warn | output | 1 | Configuration fell back (R10) |
| common_speed | output | SPD_W | Slowest present speed grade |
| common_cas | output | CL_W | Largest present CAS latency |

## Verification
The bench sweeps every granule of each configuration and a few granules past the top. This catches an off-by-one on the capacity limit, which would either hand out a granule that does not exist or refuse the last one. The populations chosen leave gaps in the slot list (slots 0,2 or 1,3 or 0,1,3). A design that indexed channels by count instead of by present slot would then steer traffic to empty slots. Flex is run with the larger module both second and first, to expose a design that always treats the later slot as the larger one or that misplaces the linear tail. Other cases cover mismatched speeds that must block interleaving, a ganged request on a flex pair that must warn and stay unganged, and a stalled response that must neither change nor let a second request in.

// File: rtl/mchan_pkg.sv
package mchan_pkg;

  // log2 of the interleave granule in bytes
  localparam int GRAN_LG = 6;

  typedef enum logic [2:0] {
    MODE_LINEAR = 3'd0,
    MODE_DUAL   = 3'd1,
    MODE_TRIPLE = 3'd2,
    MODE_QUAD   = 3'd3,
    MODE_FLEX   = 3'd4
  } ilv_mode_e;

endpackage

// File: rtl/mchan_cfg.sv
module mchan_cfg import mchan_pkg::*; #(
  parameter int NCH   = 4,
  parameter int CAP_W = 10,
  parameter int SPD_W = 4,
  parameter int CL_W  = 5,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TOT_W = CAP_W + IDX_W
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NCH-1:0]         pres_i,
  input  logic [NCH*CAP_W-1:0]   cap_i,
  input  logic [NCH*SPD_W-1:0]   spd_i,
  input  logic [NCH*CL_W-1:0]    cl_i,
  input  logic                   gang_req_i,
  output ilv_mode_e              mode_q,
  output logic                   gang_q,
  output logic                   warn_q,
  output logic [SPD_W-1:0]       spd_q,
  output logic [CL_W-1:0]        cl_q,
  output logic [NCH-1:0]         pres_q,
  output logic [NCH*CAP_W-1:0]   cap_q,
  output logic [NCH*IDX_W-1:0]   lst_q,
  output logic [TOT_W-1:0]       tot_q,
  output logic [CAP_W-1:0]       min_q,
  output logic [IDX_W-1:0]       big_q
);

  logic [CAP_W-1:0] cap_a [NCH];
  logic [SPD_W-1:0] spd_a [NCH];
  logic [CL_W-1:0]  cl_a  [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign cap_a[i] = cap_i[i*CAP_W +: CAP_W];
    assign spd_a[i] = spd_i[i*SPD_W +: SPD_W];
    assign cl_a[i]  = cl_i[i*CL_W +: CL_W];
  end

  logic [IDX_W-1:0]   lst_c [NCH];
  logic [NCH*IDX_W-1:0] lst_flat;
  logic [IDX_W:0]     cnt;
  logic               same;
  logic [CAP_W-1:0]   ref_cap, ca, cb, min_c;
  logic [SPD_W-1:0]   ref_spd, spd_min;
  logic [CL_W-1:0]    cl_max;
  logic [TOT_W-1:0]   tot_c;
  logic [IDX_W-1:0]   big_c;
  ilv_mode_e          mode_c;
  logic               gang_c, warn_c;

  // compact list of present slots, population statistics
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NCH; i++) lst_c[i] = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pres_i[i]) begin
        lst_c[cnt[IDX_W-1:0]] = IDX_W'(i);
        cnt = cnt + 1'b1;
      end
    end
    ref_cap = cap_a[lst_c[0]];
    ref_spd = spd_a[lst_c[0]];
    same    = 1'b1;
    spd_min = '1;
    cl_max  = '0;
    tot_c   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pres_i[i]) begin
        if (cap_a[i] != ref_cap || spd_a[i] != ref_spd) same = 1'b0;
        if (spd_a[i] < spd_min) spd_min = spd_a[i];
        if (cl_a[i] > cl_max) cl_max = cl_a[i];
        tot_c = tot_c + TOT_W'(cap_a[i]);
      end
    end
    if (cnt == '0) spd_min = '0;
    for (int i = 0; i < NCH; i++) lst_flat[i*IDX_W +: IDX_W] = lst_c[i];
  end

  // pair statistics used by the flex split
  always_comb begin
    ca    = cap_a[lst_c[0]];
    cb    = cap_a[lst_c[1]];
    min_c = (ca < cb) ? ca : cb;
    big_c = (ca < cb) ? lst_c[1] : lst_c[0];
  end

  // mode decision
  always_comb begin
    mode_c = MODE_LINEAR;
    if (same && cnt == (IDX_W+1)'(4) && NCH >= 4)      mode_c = MODE_QUAD;
    else if (same && cnt == (IDX_W+1)'(3) && NCH >= 3) mode_c = MODE_TRIPLE;
    else if (same && cnt == (IDX_W+1)'(2))             mode_c = MODE_DUAL;
    else if (cnt == (IDX_W+1)'(2) && spd_a[lst_c[0]] == spd_a[lst_c[1]])
                                                       mode_c = MODE_FLEX;
    gang_c = gang_req_i && (mode_c == MODE_DUAL);
    warn_c = (cnt == '0) || (gang_req_i && (mode_c != MODE_DUAL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_LINEAR;
      gang_q <= 1'b0;
      warn_q <= 1'b0;
      spd_q  <= '0;
      cl_q   <= '0;
      pres_q <= '0;
      cap_q  <= '0;
      lst_q  <= '0;
      tot_q  <= '0;
      min_q  <= '0;
      big_q  <= '0;
    end else if (load) begin
      mode_q <= mode_c;
      gang_q <= gang_c;
      warn_q <= warn_c;
      spd_q  <= spd_min;
      cl_q   <= cl_max;
      pres_q <= pres_i;
      cap_q  <= cap_i;
      lst_q  <= lst_flat;
      tot_q  <= tot_c;
      min_q  <= min_c;
      big_q  <= big_c;
    end
  end

endmodule

// File: rtl/mchan_xlate.sv
module mchan_xlate import mchan_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CAP_W  = 10,
  parameter int ADDR_W = 18,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TOT_W = CAP_W + IDX_W,
  localparam int LA_W  = CAP_W + GRAN_LG
)(
  input  logic [ADDR_W-1:0]      addr_i,
  input  ilv_mode_e              mode_i,
  input  logic                   gang_i,
  input  logic [NCH-1:0]         pres_i,
  input  logic [NCH*CAP_W-1:0]   cap_i,
  input  logic [NCH*IDX_W-1:0]   lst_i,
  input  logic [TOT_W-1:0]       tot_i,
  input  logic [CAP_W-1:0]       min_i,
  input  logic [IDX_W-1:0]       big_i,
  output logic [NCH-1:0]         ch_o,
  output logic [LA_W-1:0]        laddr_o,
  output logic                   wide_o,
  output logic                   err_o
);

  logic [CAP_W-1:0] cap_a [NCH];
  logic [IDX_W-1:0] lst   [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign cap_a[i] = cap_i[i*CAP_W +: CAP_W];
    assign lst[i]   = lst_i[i*IDX_W +: IDX_W];
  end

  int unsigned          gu, lgu, base, totu, minu;
  logic [GRAN_LG-1:0]   off;
  logic [IDX_W-1:0]     cidx;
  logic                 wide_c;

  always_comb begin
    gu     = 32'(addr_i[ADDR_W-1:GRAN_LG]);
    off    = addr_i[GRAN_LG-1:0];
    totu   = 32'(tot_i);
    minu   = 32'(min_i);
    cidx   = '0;
    lgu    = 0;
    base   = 0;
    wide_c = 1'b0;
    case (mode_i)
      MODE_DUAL: begin
        cidx   = lst[IDX_W'(gu & 32'd1)];
        lgu    = gu >> 1;
        wide_c = gang_i;
      end
      MODE_QUAD: begin
        cidx = lst[IDX_W'(gu & 32'd3)];
        lgu  = gu >> 2;
      end
      MODE_TRIPLE: begin
        cidx = lst[IDX_W'(gu % 32'd3)];
        lgu  = gu / 32'd3;
      end
      MODE_FLEX: begin
        if (gu < (minu << 1)) begin
          cidx = lst[IDX_W'(gu & 32'd1)];
          lgu  = gu >> 1;
        end else begin
          cidx = big_i;
          lgu  = gu - minu;
        end
      end
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (pres_i[i]) begin
            if (gu >= base && gu < base + 32'(cap_a[i])) begin
              cidx = IDX_W'(i);
              lgu  = gu - base;
            end
            base = base + 32'(cap_a[i]);
          end
        end
      end
    endcase
  end

  always_comb begin
    err_o   = (gu >= totu);
    ch_o    = '0;
    laddr_o = '0;
    wide_o  = 1'b0;
    if (!err_o) begin
      if (wide_c) begin
        wide_o       = 1'b1;
        ch_o[lst[0]] = 1'b1;
        ch_o[lst[1]] = 1'b1;
        laddr_o      = LA_W'(addr_i >> 1);
      end else begin
        ch_o[cidx] = 1'b1;
        laddr_o    = {CAP_W'(lgu), off};
      end
    end
  end

endmodule

// File: rtl/mchan_oreg.sv
module mchan_oreg #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/mchan_interleaver.sv
module mchan_interleaver import mchan_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CAP_W  = 10,
  parameter int SPD_W  = 4,
  parameter int CL_W   = 5,
  parameter int ADDR_W = 18,
  localparam int LA_W  = CAP_W + GRAN_LG
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [NCH-1:0]       cfg_present,
  input  logic [NCH*CAP_W-1:0] cfg_cap,
  input  logic [NCH*SPD_W-1:0] cfg_speed,
  input  logic [NCH*CL_W-1:0]  cfg_cas,
  input  logic                 cfg_gang_req,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [NCH-1:0]       rsp_ch,
  output logic [LA_W-1:0]      rsp_laddr,
  output logic                 rsp_wide,
  output logic                 rsp_err,
  output logic [2:0]           mode,
  output logic                 ganged,
  output logic                 cfg_warn,
  output logic [SPD_W-1:0]     common_speed,
  output logic [CL_W-1:0]      common_cas
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TOT_W = CAP_W + IDX_W;
  localparam int PW    = NCH + LA_W + 2;

  ilv_mode_e            mode_q;
  logic [NCH-1:0]       pres_q;
  logic [NCH*CAP_W-1:0] cap_q;
  logic [NCH*IDX_W-1:0] lst_q;
  logic [TOT_W-1:0]     tot_q;
  logic [CAP_W-1:0]     min_q;
  logic [IDX_W-1:0]     big_q;

  mchan_cfg #(.NCH(NCH), .CAP_W(CAP_W), .SPD_W(SPD_W), .CL_W(CL_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .pres_i     (cfg_present),
    .cap_i      (cfg_cap),
    .spd_i      (cfg_speed),
    .cl_i       (cfg_cas),
    .gang_req_i (cfg_gang_req),
    .mode_q     (mode_q),
    .gang_q     (ganged),
    .warn_q     (cfg_warn),
    .spd_q      (common_speed),
    .cl_q       (common_cas),
    .pres_q     (pres_q),
    .cap_q      (cap_q),
    .lst_q      (lst_q),
    .tot_q      (tot_q),
    .min_q      (min_q),
    .big_q      (big_q)
  );

  logic [NCH-1:0]  x_ch;
  logic [LA_W-1:0] x_laddr;
  logic            x_wide, x_err;

  mchan_xlate #(.NCH(NCH), .CAP_W(CAP_W), .ADDR_W(ADDR_W)) u_xlate (
    .addr_i  (req_addr),
    .mode_i  (mode_q),
    .gang_i  (ganged),
    .pres_i  (pres_q),
    .cap_i   (cap_q),
    .lst_i   (lst_q),
    .tot_i   (tot_q),
    .min_i   (min_q),
    .big_i   (big_q),
    .ch_o    (x_ch),
    .laddr_o (x_laddr),
    .wide_o  (x_wide),
    .err_o   (x_err)
  );

  logic [PW-1:0] pk_in, pk_out;
  assign pk_in = {x_wide, x_err, x_ch, x_laddr};

  mchan_oreg #(.W(PW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pk_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pk_out)
  );

  assign {rsp_wide, rsp_err, rsp_ch, rsp_laddr} = pk_out;
  assign mode = mode_q;

endmodule

// File: rtl/mchan_interleaver_chk.sv
module mchan_interleaver_chk #(
  parameter int NCH  = 4,
  parameter int LA_W = 16
)(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [NCH-1:0]  rsp_ch,
  input logic [LA_W-1:0] rsp_laddr,
  input logic            rsp_wide,
  input logic            rsp_err,
  input logic [2:0]      mode,
  input logic            ganged,
  input logic            cfg_warn
);

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_wide && !rsp_err |-> $onehot0(rsp_ch) && rsp_ch != '0); // R7
  AST_WIDE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wide |-> $countones(rsp_ch) == 2); // R6
  AST_ERR_NO_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_ch == '0 && !rsp_wide); // R8
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ch) && $stable(rsp_laddr)
      && $stable(rsp_wide) && $stable(rsp_err)); // R11
  AST_GANG_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ganged |-> mode == 3'd1 && !cfg_warn); // R10

endmodule

bind mchan_interleaver mchan_interleaver_chk #(.NCH(NCH), .LA_W(LA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ch    (rsp_ch),
  .rsp_laddr (rsp_laddr),
  .rsp_wide  (rsp_wide),
  .rsp_err   (rsp_err),
  .mode      (mode),
  .ganged    (ganged),
  .cfg_warn  (cfg_warn)
);

// File: tb/sim_mchan_interleaver.sv
module sim_mchan_interleaver;

  localparam int NCH = 4, CAP_W = 10, SPD_W = 4, CL_W = 5, ADDR_W = 18;
  localparam int LA_W = CAP_W + 6;

  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_gang_req = 1'b0;
  logic [NCH-1:0] cfg_present = '0;
  logic [NCH*CAP_W-1:0] cfg_cap = '0;
  logic [NCH*SPD_W-1:0] cfg_speed = '0;
  logic [NCH*CL_W-1:0] cfg_cas = '0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_wide, rsp_err, ganged, cfg_warn;
  logic [NCH-1:0] rsp_ch;
  logic [LA_W-1:0] rsp_laddr;
  logic [2:0] mode;
  logic [SPD_W-1:0] common_speed;
  logic [CL_W-1:0] common_cas;

  always #10 clk = ~clk;

  mchan_interleaver #(.NCH(NCH), .CAP_W(CAP_W), .SPD_W(SPD_W), .CL_W(CL_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_present(cfg_present),
    .cfg_cap(cfg_cap), .cfg_speed(cfg_speed), .cfg_cas(cfg_cas), .cfg_gang_req(cfg_gang_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ch(rsp_ch), .rsp_laddr(rsp_laddr),
    .rsp_wide(rsp_wide), .rsp_err(rsp_err), .mode(mode), .ganged(ganged),
    .cfg_warn(cfg_warn), .common_speed(common_speed), .common_cas(common_cas));

  int n_total = 0, n_bad = 0;
  bit done = 0;

  // bench-side configuration and expectations
  int bp[4], bc[4], bs[4], bl[4];
  int bgang;
  int e_mode, e_gang, e_warn, e_spd, e_cl, e_tot, e_n;
  int blst[4];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_cfg();
    bit same;
    e_n = 0;
    for (int i = 0; i < 4; i++) blst[i] = 0;
    for (int i = 0; i < 4; i++) if (bp[i] != 0) begin blst[e_n] = i; e_n++; end
    same = 1; e_spd = 99; e_cl = 0; e_tot = 0;
    for (int i = 0; i < 4; i++) if (bp[i] != 0) begin
      if (bc[i] != bc[blst[0]] || bs[i] != bs[blst[0]]) same = 0;
      if (bs[i] < e_spd) e_spd = bs[i];
      if (bl[i] > e_cl) e_cl = bl[i];
      e_tot += bc[i];
    end
    if (e_n == 0) e_spd = 0;
    if (same && e_n == 4) e_mode = 3;
    else if (same && e_n == 3) e_mode = 2;
    else if (same && e_n == 2) e_mode = 1;
    else if (e_n == 2 && bs[blst[0]] == bs[blst[1]]) e_mode = 4;
    else e_mode = 0;
    e_gang = (bgang != 0 && e_mode == 1) ? 1 : 0;
    e_warn = (e_n == 0 || (bgang != 0 && e_mode != 1)) ? 1 : 0;
  endfunction

  function automatic void model_map(input int addr, output int ch, output int la,
                                    output int wd, output int er);
    int g, off, c, lg, m, base;
    g = addr / 64; off = addr % 64;
    ch = 0; la = 0; wd = 0; c = 0; lg = 0;
    er = (g >= e_tot) ? 1 : 0;
    if (er != 0) return;
    case (e_mode)
      1: begin
        if (e_gang != 0) begin
          ch = (1 << blst[0]) | (1 << blst[1]); la = addr / 2; wd = 1; return;
        end
        c = blst[g % 2]; lg = g / 2;
      end
      3: begin c = blst[g % 4]; lg = g / 4; end
      2: begin c = blst[g % 3]; lg = g / 3; end
      4: begin
        m = (bc[blst[0]] < bc[blst[1]]) ? bc[blst[0]] : bc[blst[1]];
        if (g < 2 * m) begin c = blst[g % 2]; lg = g / 2; end
        else begin c = (bc[blst[0]] < bc[blst[1]]) ? blst[1] : blst[0]; lg = g - m; end
      end
      default: begin
        base = 0;
        for (int i = 0; i < 4; i++) if (bp[i] != 0) begin
          if (g >= base && g < base + bc[i]) begin c = i; lg = g - base; end
          base += bc[i];
        end
      end
    endcase
    ch = 1 << c; la = lg * 64 + off;
  endfunction

  task automatic set_slots(input int p0, c0, s0, l0, p1, c1, s1, l1,
                           p2, c2, s2, l2, p3, c3, s3, l3, input int gang);
    bp = '{p0, p1, p2, p3}; bc = '{c0, c1, c2, c3};
    bs = '{s0, s1, s2, s3}; bl = '{l0, l1, l2, l3};
    bgang = gang;
  endtask

  task automatic apply_cfg(input string req);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      cfg_present[i] = (bp[i] != 0);
      cfg_cap[i*CAP_W +: CAP_W] = CAP_W'(bc[i]);
      cfg_speed[i*SPD_W +: SPD_W] = SPD_W'(bs[i]);
      cfg_cas[i*CL_W +: CL_W] = CL_W'(bl[i]);
    end
    cfg_gang_req = (bgang != 0);
    cfg_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    model_cfg();
    check(req, "mode", int'(mode), e_mode);
    check("R10", "ganged", int'(ganged), e_gang);
    check("R10", "warn", int'(cfg_warn), e_warn);
    check("R9", "speed", int'(common_speed), e_spd);
    check("R9", "cas", int'(common_cas), e_cl);
  endtask

  // one request, response checked at the following falling edge
  task automatic send(input int addr, input string req);
    int ch, la, wd, er;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(addr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    model_map(addr, ch, la, wd, er);
    check("R11", "rsp_valid", int'(rsp_valid), 1);
    check(er != 0 ? "R8" : req, "ch", int'(rsp_ch), ch);
    check(er != 0 ? "R8" : req, "laddr", int'(rsp_laddr), la);
    check(er != 0 ? "R8" : (wd != 0 ? "R6" : "R7"), "wide", int'(rsp_wide), wd);
    check("R8", "err", int'(rsp_err), er);
  endtask

  task automatic sweep(input string req);
    for (int g = 0; g < e_tot + 3; g++) send(g * 64 + (g * 13 + 5) % 64, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "mode", int'(mode), 0);
    check("R12", "ganged", int'(ganged), 0);
    check("R12", "warn", int'(cfg_warn), 0);
    check("R12", "rsp_valid", int'(rsp_valid), 0);
    check("R11", "req_ready", int'(req_ready), 1);
    set_slots(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0, 0);
    e_mode = 0; e_gang = 0; e_tot = 0;
    send(0, "R12");

    // no module at all: warning, every address errors
    apply_cfg("R10");
    sweep("R10");

    // single module in slot 2
    set_slots(0,0,0,0, 0,0,0,0, 1,8,5,9, 0,0,0,0, 0);
    apply_cfg("R1"); sweep("R5");

    // dual on slots 0 and 2, unganged then ganged
    set_slots(1,8,6,11, 0,0,0,0, 1,8,6,9, 0,0,0,0, 0);
    apply_cfg("R1"); sweep("R2");
    bgang = 1;
    apply_cfg("R6"); sweep("R6");

    // flex, larger module second; ganged request must warn
    set_slots(0,0,0,0, 1,4,5,9, 0,0,0,0, 1,12,5,10, 1);
    apply_cfg("R4"); sweep("R4");
    // flex, larger module first
    set_slots(1,10,7,8, 0,0,0,0, 1,3,7,8, 0,0,0,0, 0);
    apply_cfg("R4"); sweep("R4");

    // triple on slots 0,1,3
    set_slots(1,6,5,9, 1,6,5,12, 0,0,0,0, 1,6,5,10, 0);
    apply_cfg("R1"); sweep("R3");

    // quad with differing latencies
    set_slots(1,5,6,9, 1,5,6,13, 1,5,6,10, 1,5,6,11, 0);
    apply_cfg("R1"); sweep("R2");

    // R12: inputs change without a strobe
    @(negedge clk);
    cfg_present = 4'b0001; cfg_gang_req = 1'b1;
    cfg_cap = '0;
    repeat (2) @(negedge clk);
    check("R12", "mode held", int'(mode), 3);
    check("R12", "warn held", int'(cfg_warn), 0);
    send(7 * 64 + 3, "R12");
    send(19 * 64, "R12");

    // four modules with a speed mismatch: linear
    set_slots(1,3,5,9, 1,4,3,11, 1,5,7,7, 1,6,5,10, 0);
    apply_cfg("R1"); sweep("R5");

    // two equal sizes, different speeds: linear
    set_slots(0,0,0,0, 1,5,4,9, 1,5,6,9, 0,0,0,0, 0);
    apply_cfg("R1"); sweep("R5");

    // R11 back-pressure
    set_slots(1,8,6,11, 0,0,0,0, 1,8,6,9, 0,0,0,0, 0);
    apply_cfg("R1");
    begin
      int ch, la, wd, er;
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_addr = ADDR_W'(3 * 64 + 9);
      @(posedge clk);
      @(negedge clk);
      req_addr = ADDR_W'(4 * 64 + 1);
      check("R11", "ready low in stall", int'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
      model_map(3 * 64 + 9, ch, la, wd, er);
      check("R11", "held ch", int'(rsp_ch), ch);
      check("R11", "held laddr", int'(rsp_laddr), la);
      check("R11", "held valid", int'(rsp_valid), 1);
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      model_map(4 * 64 + 1, ch, la, wd, er);
      check("R11", "next ch", int'(rsp_ch), ch);
      check("R11", "next laddr", int'(rsp_laddr), la);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule